// File: doc/BRIEF.md
# Edge-Interrupt General-Purpose I/O Port

This block is an eight-line general-purpose I/O port that sits on a simple register bus. Each line can be set as an input or an output, and the lines can be mixed freely. Output lines drive the value stored for them and assert their pad enable. Input lines are left undriven, so the pad is high impedance. Pin levels are brought into the clock domain through a synchronizer before anything else uses them.

Each line can also act as its own interrupt source. A per-line polarity bit chooses whether a rising or a falling transition counts. A per-line enable bit decides whether that transition is latched in a sticky pending flag. The single interrupt request output is the OR of the pending flags whose enables are set. Software clears pending flags by writing ones to them.

Reading the data address returns a merged byte: output lines report their stored data bit, and input lines report the synchronized pin level. A line can therefore serve as a data pin, as a handshake line, or as a dedicated interrupt input.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads 0 (data at address 0, direction at 1, polarity at 2, enable at 3, pending at 4), `pin_oe` is 0 and `irq` is 0. Addresses 5 to 7 read 0.
- R2: A write to address 1 (direction; bit = 1 means output) appears on `pin_oe` in the next cycle. A write to address 0 appears on `pin_out` in the next cycle.
- R3: A read of address 0 returns, for each bit, the data register bit when the line's direction bit is 1, and the synchronized pin level when it is 0.
- R4: A pin change becomes visible in the address-0 readback exactly two clock edges after it is applied, not one.
- R5: With polarity bit 0, a high-to-low transition on an enabled line sets its pending bit. A low-to-high transition does not.
- R6: With polarity bit 1, a low-to-high transition on an enabled line sets its pending bit. A high-to-low transition does not.
- R7: A transition on a line whose enable bit (address 3) is 0 never sets that line's pending bit.
- R8: Writing address 4 clears each pending bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R9: If a pending-clear write and a new qualifying edge hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` is 1 exactly when some bit is both pending and enabled. Clearing an enable lowers `irq` while the pending bit is kept.
- R11: Edge detection follows the pin level even on lines configured as outputs.
- R12: The direction, polarity and enable registers read back at addresses 1, 2 and 3 with the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with its default width of eight lines and a two-stage synchronizer. At that width every line can be given a different role in one configuration: high lines are outputs with falling polarity and low lines are inputs with rising polarity. With two synchronizer stages the exact readback latency, and the cycle in which a clear write collides with a fresh edge, can be hit on purpose. The mix also lets one stimulus show at once an edge that is taken, an edge of the wrong polarity that is ignored, and an edge taken on an output line.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_POL  = 3'd2,
        SEL_IEN  = 3'd3,
        SEL_PEND = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_insync.sv
module gpio_insync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] level
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = raw_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edgedet.sv
module gpio_edgedet #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_sel,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        assign hit[i] = rise_sel[i] ? (level[i] & ~prev_q[i])
                                    : (~level[i] & prev_q[i]);
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] dir;
        logic [W-1:0] pol;
        logic [W-1:0] ien;
        logic [W-1:0] pend;
    } port_state_t;

    port_state_t  st_d, st_q;
    logic [W-1:0] pin_level;
    logic [W-1:0] line_hit;
    logic [W-1:0] clr_mask;

    gpio_insync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pin_in),
        .level  (pin_level)
    );

    gpio_edgedet #(.W(W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_level),
        .rise_sel (st_q.pol),
        .hit      (line_hit)
    );

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (bus_wr) begin
            case (bus_addr)
                SEL_DATA: st_d.data = bus_wdata;
                SEL_DIR:  st_d.dir  = bus_wdata;
                SEL_POL:  st_d.pol  = bus_wdata;
                SEL_IEN:  st_d.ien  = bus_wdata;
                SEL_PEND: clr_mask  = bus_wdata;
                default:  ;
            endcase
        end
        // a fresh qualifying edge outranks a simultaneous clear
        st_d.pend = (st_q.pend & ~clr_mask) | (line_hit & st_q.ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            SEL_DATA: bus_rdata = (st_q.data & st_q.dir) | (pin_level & ~st_q.dir);
            SEL_DIR:  bus_rdata = st_q.dir;
            SEL_POL:  bus_rdata = st_q.pol;
            SEL_IEN:  bus_rdata = st_q.ien;
            SEL_PEND: bus_rdata = st_q.pend;
            default:  bus_rdata = '0;
        endcase
    end

    assign pin_out = st_q.data;
    assign pin_oe  = st_q.dir;
    assign irq     = |(st_q.pend & st_q.ien);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   bus_addr,
    input logic         bus_wr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] pin_oe,
    input logic         irq,
    input logic [W-1:0] pend,
    input logic [W-1:0] ien,
    input logic [W-1:0] hit
);
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd1) |=> (pin_oe == $past(bus_wdata)));

    assert_no_masked_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(ien)) == '0));

    assert_clear_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4) |=>
        ((pend & $past(bus_wdata) & ~$past(hit & ien)) == '0));

    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & ien) != '0) |=> ((pend & $past(hit & ien)) == $past(hit & ien)));

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend & ien) != '0));
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .pend      (st_q.pend),
    .ien       (st_q.ien),
    .hit       (line_hit)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
    localparam int SRC_RD  = 0;
    localparam int SRC_OE  = 1;
    localparam int SRC_OUT = 2;
    localparam int SRC_IRQ = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] bus_rdata, pin_out, pin_oe;
    logic       irq;

    always #4 clk = ~clk;

    gpio_port uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct {
        string      req;
        int         src;
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];
    logic  chk_valid = 1'b0;
    logic  done = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;

    // monitor: pops the expected item and compares at the falling edge
    always @(negedge clk) begin
        item_t      it;
        logic [7:0] act;
        if (chk_valid && sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.src)
                SRC_RD:  act = bus_rdata;
                SRC_OE:  act = pin_oe;
                SRC_OUT: act = pin_out;
                default: act = {7'b0, irq};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
            end
        end
    end

    task automatic expect_val(input string req, input int src,
                              input logic [2:0] a, input logic [7:0] e);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.req = req; it.src = src; it.exp = e;
        sb_q.push_back(it);
        chk_valid = 1'b1;
        @(negedge clk); #1;
        chk_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic set_pin(input logic [7:0] v);
        @(posedge clk); #1;
        pin_in = v;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) expect_val("R1 reg", SRC_RD, 3'(a), 8'h00);
        expect_val("R1 oe", SRC_OE, 3'd0, 8'h00);
        expect_val("R1 irq", SRC_IRQ, 3'd0, 8'h00);

        // R2 / R12: direction and data
        wr(3'd1, 8'hF0);
        wr(3'd0, 8'hA5);
        expect_val("R2 oe", SRC_OE, 3'd0, 8'hF0);
        expect_val("R2 out", SRC_OUT, 3'd0, 8'hA5);
        expect_val("R12 dir", SRC_RD, 3'd1, 8'hF0);

        // R3: merged readback
        set_pin(8'h3C);
        settle();
        expect_val("R3 merge", SRC_RD, 3'd0, 8'hAC);

        // R4: two-edge latency
        set_pin(8'h3F);
        expect_val("R4 early", SRC_RD, 3'd0, 8'hAC);
        expect_val("R4 ready", SRC_RD, 3'd0, 8'hAF);

        // R7: edges with enables clear set nothing
        set_pin(8'h3B);
        settle();
        expect_val("R7 masked", SRC_RD, 3'd4, 8'h00);

        // R12: polarity and enable
        wr(3'd2, 8'h0F);
        wr(3'd3, 8'hFF);
        expect_val("R12 pol", SRC_RD, 3'd2, 8'h0F);
        expect_val("R12 ien", SRC_RD, 3'd3, 8'hFF);

        // R5 R6 R11: bit4 (output line, falling) taken, bit0 falling with rising pol ignored
        set_pin(8'h2A);
        settle();
        expect_val("R5 R6 R11 fall", SRC_RD, 3'd4, 8'h10);
        expect_val("R10 irq on", SRC_IRQ, 3'd0, 8'h01);
        // R6: rising on bit2
        set_pin(8'h2E);
        settle();
        expect_val("R6 rise", SRC_RD, 3'd4, 8'h14);

        // R8: zeros keep, ones clear
        wr(3'd4, 8'h00);
        expect_val("R8 keep", SRC_RD, 3'd4, 8'h14);
        wr(3'd4, 8'h04);
        expect_val("R8 clear", SRC_RD, 3'd4, 8'h10);

        // R10: enable masks irq, pending kept
        wr(3'd3, 8'hEF);
        expect_val("R10 irq masked", SRC_IRQ, 3'd0, 8'h00);
        expect_val("R10 pend kept", SRC_RD, 3'd4, 8'h10);
        wr(3'd3, 8'hFF);
        expect_val("R10 irq back", SRC_IRQ, 3'd0, 8'h01);
        wr(3'd4, 8'h10);
        expect_val("R10 irq off", SRC_IRQ, 3'd0, 8'h00);

        // R9: clear colliding with a new edge
        set_pin(8'h2F);
        settle();
        set_pin(8'h2C);
        settle();
        set_pin(8'h2E);
        settle();
        expect_val("R9 setup", SRC_RD, 3'd4, 8'h03);
        set_pin(8'h2F);
        @(posedge clk);
        wr(3'd4, 8'h03);
        expect_val("R9 edge wins", SRC_RD, 3'd4, 8'h01);
        expect_val("R9 irq", SRC_IRQ, 3'd0, 8'h01);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule